// File: doc/BRIEF.md
# External Interrupt Detector

This block turns a small set of external interrupt request pins into interrupt request lines for an interrupt controller. Every pin is first brought into the local clock domain through a multi-flop synchroniser. Each pin can be set up for one of two detection styles. In level style, a low pin is a request for as long as the pin stays low. In edge style, a qualifying transition sets a sticky per-pin flag. The qualifying transition can be a falling edge, a rising edge or both. The flag stays set until software clears it.

Configuration lives in two 16-bit registers behind a simple single-cycle register port: a sense register and an edge-mode register. A third address gives access to the sticky flags, where reads show the flags and writes of 1 clear them. A read returns its data in the same cycle, combinationally from the address. A write is taken at the rising clock edge. When a pin's configuration changes, the block discards that pin's previous-sample history, so that reconfiguring a pin cannot by itself raise a request.

Top module: `extint_detector`

## Requirements
- R1: After reset, every readable register reads 0, all pins are in level style, all flags are clear, and with all pins high `irq_o` is 0.
- R2: Address 0 is the sense register. Bit i selects the style of pin i: 0 is level, 1 is edge. Bits 3:0 read back what was written.
- R3: Address 1 is the edge-mode register. Pin i uses bits [15-2i:14-2i]. Code 00 detects falling edges, 01 rising edges and 10 both. All of bits 15:8 read back what was written.
- R4: Reserved bits always read 0 and ignore written values. These are bits 15:4 at address 0, bits 7:0 at address 1 and bits 15:4 at address 2. Every bit of address 3 is reserved, and a write to address 3 changes nothing.
- R5: In level style, `irq_o[i]` is the inverse of `pin_i[i]`. A pin change made between clock edges shows at the output after the second rising edge that follows it, and not after the first.
- R6: In edge style, a transition that matches the pin's code sets its flag, and `irq_o[i]` then shows the flag. The flag becomes visible after the third rising edge that follows the pin change. A transition that does not match the code leaves the flag clear.
- R7: Flags are sticky. Writing 1 to bit i at address 2 clears flag i, and writing 0 leaves it unchanged. Bits 3:0 at address 2 read the flags.
- R8: If a qualifying edge and a clear of the same flag occur in the same cycle, the flag stays set.
- R9: Edge-mode code 11 detects nothing, so in edge style a pin with code 11 never raises a request.
- R10: When a write changes a pin's sense bit or its edge-mode field, the pin's history is cleared. An edge whose synchronised transition lands on that same clock edge is therefore not detected.
- R11: In level style, transitions never set the pin's flag, whatever edge-mode code is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Raw external request pins |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from `reg_addr` |
| irq_o | output | NUM_PINS | Per-pin interrupt requests |

## Verification
A wrong flag or history bit shows up in `irq_o` at the first sampling point after the third rising edge that follows the stimulating pin change. It shows up sooner in the flag read at address 2, right after the clear or write that should have acted on it. A corrupted synchroniser stage shows up in the level-style output two edges after the pin change. A corrupted configuration register shows up in the next combinational read. The sweep drives every pin with every edge-mode code and both transition directions. A fault that is confined to one pin, one code or one direction therefore shows up as a miscompare in that particular vector.

// File: rtl/extint_pkg.sv
package extint_pkg;

   // Edge qualification codes stored per pin in the mode register
   typedef enum logic [1:0] {
      EDGE_FALL = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_BOTH = 2'b10,
      EDGE_NONE = 2'b11
   } edge_mode_e;

   // Register map (word addresses)
   localparam int unsigned ADDR_SENSE = 0;
   localparam int unsigned ADDR_MODE  = 1;
   localparam int unsigned ADDR_FLAG  = 2;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int unsigned WIDTH   = 4,
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("extint_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= {(STAGES*WIDTH){RST_VAL}};
      end else begin
         stg_q[0] <= d;
         for (int k = 1; k < STAGES; k++) begin
            stg_q[k] <= stg_q[k-1];
         end
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/extint_regs.sv
module extint_regs
   import extint_pkg::*;
#(
   parameter int unsigned NUM_PINS = 4,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ADDR_W   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [NUM_PINS-1:0]      flag,
   output logic [DATA_W-1:0]        rdata,
   output logic [NUM_PINS-1:0]      sense,
   output logic [NUM_PINS-1:0][1:0] mode,
   output logic [NUM_PINS-1:0]      clr,
   output logic [NUM_PINS-1:0]      chg
);

   localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(ADDR_SENSE);
   localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(ADDR_MODE);
   localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(ADDR_FLAG);

   logic [NUM_PINS-1:0]      sense_q;
   logic [NUM_PINS-1:0][1:0] mode_q;
   logic [NUM_PINS-1:0][1:0] mode_wr;
   logic                     wr_sense, wr_mode, wr_flag;
   logic [DATA_W-1:0]        rd_mode;
   logic                     unused_wdata;

   assign wr_sense     = wr_en && (addr == A_SENSE);
   assign wr_mode      = wr_en && (addr == A_MODE);
   assign wr_flag      = wr_en && (addr == A_FLAG);
   assign unused_wdata = ^wdata;

   // Field of pin i sits at [DATA_W-1-2i -: 2]
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_field
      assign mode_wr[i] = wdata[DATA_W-1-2*i -: 2];
      assign chg[i]     = (wr_sense && (wdata[i] != sense_q[i])) ||
                          (wr_mode  && (mode_wr[i] != mode_q[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= '0;
         mode_q  <= '0;
      end else begin
         if (wr_sense) sense_q <= wdata[NUM_PINS-1:0];
         if (wr_mode)  mode_q  <= mode_wr;
      end
   end

   assign clr   = wr_flag ? wdata[NUM_PINS-1:0] : '0;
   assign sense = sense_q;
   assign mode  = mode_q;

   always_comb begin
      rd_mode = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         rd_mode[DATA_W-1-2*i -: 2] = mode_q[i];
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_SENSE)     rdata[NUM_PINS-1:0] = sense_q;
      else if (addr == A_MODE) rdata = rd_mode;
      else if (addr == A_FLAG) rdata[NUM_PINS-1:0] = flag;
   end

endmodule

// File: rtl/extint_pin_cell.sv
module extint_pin_cell
   import extint_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync,
   input  logic       sense,
   input  logic [1:0] mode,
   input  logic       clr,
   input  logic       chg,
   output logic       evt,
   output logic       flag,
   output logic       req
);

   logic prev_q, hist_q, flag_q;
   logic rise, fall, qual;

   assign rise = sync & ~prev_q;
   assign fall = ~sync & prev_q;

   always_comb begin
      case (edge_mode_e'(mode))
         EDGE_FALL: qual = fall;
         EDGE_RISE: qual = rise;
         EDGE_BOTH: qual = rise | fall;
         default:   qual = 1'b0;
      endcase
   end

   assign evt = sense & hist_q & qual;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         hist_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= sync;
         hist_q <= ~chg;
         if (evt)      flag_q <= 1'b1;
         else if (clr) flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;
   assign req  = sense ? flag_q : ~sync;

endmodule

// File: rtl/extint_detector.sv
module extint_detector
   import extint_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 4,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                reg_wr_en,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic [NUM_PINS-1:0] irq_o
);

   if (NUM_PINS < 1 || DATA_W < 2*NUM_PINS || DATA_W <= NUM_PINS) begin : g_bad_width
      $error("extint_detector: DATA_W too narrow for NUM_PINS mode fields");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("extint_detector: ADDR_W must be at least 2");
   end

   logic [NUM_PINS-1:0]      pin_sync;
   logic [NUM_PINS-1:0]      sense_q;
   logic [NUM_PINS-1:0][1:0] mode_q;
   logic [NUM_PINS-1:0]      clr_pulse;
   logic [NUM_PINS-1:0]      cfg_chg;
   logic [NUM_PINS-1:0]      edge_evt;
   logic [NUM_PINS-1:0]      flag_q;

   extint_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_i),
      .q    (pin_sync)
   );

   extint_regs #(
      .NUM_PINS(NUM_PINS),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(reg_wr_en),
      .addr (reg_addr),
      .wdata(reg_wdata),
      .flag (flag_q),
      .rdata(reg_rdata),
      .sense(sense_q),
      .mode (mode_q),
      .clr  (clr_pulse),
      .chg  (cfg_chg)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      extint_pin_cell u_cell (
         .clk  (clk),
         .rst_n(rst_n),
         .sync (pin_sync[i]),
         .sense(sense_q[i]),
         .mode (mode_q[i]),
         .clr  (clr_pulse[i]),
         .chg  (cfg_chg[i]),
         .evt  (edge_evt[i]),
         .flag (flag_q[i]),
         .req  (irq_o[i])
      );
   end

endmodule

// File: rtl/extint_checker.sv
module extint_checker #(
   parameter int unsigned NUM_PINS = 4,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ADDR_W   = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_PINS-1:0]      pin_i,
   input logic [ADDR_W-1:0]        reg_addr,
   input logic [DATA_W-1:0]        reg_rdata,
   input logic [NUM_PINS-1:0]      irq_o,
   input logic [NUM_PINS-1:0]      sense,
   input logic [NUM_PINS-1:0][1:0] mode,
   input logic [NUM_PINS-1:0]      evt,
   input logic [NUM_PINS-1:0]      flag,
   input logic [NUM_PINS-1:0]      clr,
   input logic [NUM_PINS-1:0]      chg
);

   localparam int unsigned MODE_LSB = DATA_W - 2*NUM_PINS;

   logic [1:0] live_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              live_cnt <= '0;
      else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
   end

   AST_RSVD_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(0)) |-> (reg_rdata[DATA_W-1:NUM_PINS] == '0)); // R4
   AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(2)) |-> (reg_rdata[DATA_W-1:NUM_PINS] == '0)); // R4

   if (MODE_LSB > 0) begin : g_rsvd_mode
      AST_RSVD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_addr == ADDR_W'(1)) |-> (reg_rdata[MODE_LSB-1:0] == '0)); // R4
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
      AST_LEVEL_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
         (live_cnt == 2'd3 && !sense[i]) |-> (irq_o[i] == !$past(pin_i[i], 2))); // R5
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(flag[i]) && !$past(clr[i])) |-> flag[i]); // R7
      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(clr[i]) && !$past(evt[i])) |-> !flag[i]); // R7
      AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         $past(evt[i]) |-> flag[i]); // R8
      AST_NONE_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (mode[i] == 2'b11) |-> !evt[i]); // R9
      AST_CFG_NO_FALSE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
         $past(chg[i]) |-> !evt[i]); // R10
      AST_LEVEL_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
         !sense[i] |-> !evt[i]); // R11
   end

endmodule

bind extint_detector extint_checker #(
   .NUM_PINS(NUM_PINS),
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pin_i    (pin_i),
   .reg_addr (reg_addr),
   .reg_rdata(reg_rdata),
   .irq_o    (irq_o),
   .sense    (sense_q),
   .mode     (mode_q),
   .evt      (edge_evt),
   .flag     (flag_q),
   .clr      (clr_pulse),
   .chg      (cfg_chg)
);

// File: tb/sim_extint_detector.sv
`timescale 1ns/1ps
module sim_extint_detector;

   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  pins = 4'hF;
   logic        we = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [3:0]  irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   extint_detector u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (pins),
      .reg_wr_en(we),
      .reg_addr (addr),
      .reg_wdata(wdata),
      .reg_rdata(rdata),
      .irq_o    (irq)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic expect_hit(input int code, input bit rising);
      return (code == 0 && !rising) || (code == 1 && rising) || (code == 2);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic [15:0] pats [4];
      pats[0] = 16'hFFFF; pats[1] = 16'hA5A5; pats[2] = 16'h5A5A; pats[3] = 16'h0000;

      idle(3);
      rst_n = 1'b1;
      idle(3);

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk("R1 reset readback", v, 16'h0000);
      end
      chk("R1 reset irq", {12'h0, irq}, 16'h0000);

      // R2 R3 R4 readback with reserved masking
      for (int p = 0; p < 4; p++) begin
         wr(2'd0, pats[p]);
         wr(2'd1, pats[p]);
         wr(2'd3, 16'hFFFF);
         rd(2'd0, v); chk("R2 sense readback", v, pats[p] & 16'h000F);
         rd(2'd1, v); chk("R3 mode readback",  v, pats[p] & 16'hFF00);
         rd(2'd3, v); chk("R4 reserved address", v, 16'h0000);
         rd(2'd2, v); chk("R4 flag reserved bits", v & 16'hFFF0, 16'h0000);
      end
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'h0000);
      wr(2'd2, 16'h000F);
      idle(3);

      // R5 level latency on pin 1
      @(negedge clk); pins[1] = 1'b0;
      @(negedge clk); chk("R5 level after 1 edge", {12'h0, irq}, 16'h0000);
      @(negedge clk); chk("R5 level after 2 edges", {12'h0, irq}, 16'h0002);
      @(negedge clk); pins[1] = 1'b1;
      idle(2);        chk("R5 level release", {12'h0, irq}, 16'h0000);

      // R11 level style ignores edges for flags (mode both stored)
      wr(2'd1, 16'hAA00);
      @(negedge clk); pins = 4'h0;
      idle(3); pins = 4'hF;
      idle(4);
      rd(2'd2, v); chk("R11 no flags in level style", v, 16'h0000);

      // R6 latency: pin 2 rising edge
      wr(2'd1, 16'h0400);
      @(negedge clk); pins[2] = 1'b0;
      idle(4);
      wr(2'd0, 16'h0004);
      wr(2'd2, 16'h000F);
      idle(2);
      @(negedge clk); pins[2] = 1'b1;
      @(negedge clk); chk("R6 edge after 1 edge", {12'h0, irq}, 16'h0000);
      @(negedge clk); chk("R6 edge after 2 edges", {12'h0, irq}, 16'h0000);
      @(negedge clk); chk("R6 edge after 3 edges", {12'h0, irq}, 16'h0004);
      rd(2'd2, v);    chk("R7 flag readback", v, 16'h0004);

      // R7 write 0 keeps, write 1 clears
      wr(2'd2, 16'h000B);
      rd(2'd2, v);    chk("R7 zero bit keeps flag", v, 16'h0004);
      wr(2'd2, 16'h0004);
      rd(2'd2, v);    chk("R7 one bit clears flag", v, 16'h0000);
      chk("R7 irq after clear", {12'h0, irq}, 16'h0000);

      // R8 edge and clear collide on pin 0 (both edges)
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'h8000);
      @(negedge clk); pins = 4'hF;
      idle(4);
      wr(2'd0, 16'h0001);
      wr(2'd2, 16'h000F);
      idle(2);
      @(negedge clk); pins[0] = 1'b0;
      idle(4);
      chk("R8 setup flag", {12'h0, irq} & 16'h0001, 16'h0001);
      @(negedge clk); pins[0] = 1'b1;
      @(negedge clk);
      @(negedge clk); we = 1'b1; addr = 2'd2; wdata = 16'h0001;
      @(negedge clk); we = 1'b0;
      chk("R8 edge beats clear", {12'h0, irq} & 16'h0001, 16'h0001);
      wr(2'd2, 16'h0001);
      chk("R8 later clear", {12'h0, irq} & 16'h0001, 16'h0000);

      // R10 config change masks a coincident edge on pin 0 (falling code)
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'h0000);
      wr(2'd2, 16'h000F);
      idle(3);
      @(negedge clk); pins[0] = 1'b0;
      @(negedge clk); we = 1'b1; addr = 2'd0; wdata = 16'h0001;
      @(negedge clk); we = 1'b0;
      idle(3);
      chk("R10 no edge on config change", {12'h0, irq} & 16'h0001, 16'h0000);
      rd(2'd2, v); chk("R10 flag stays clear", v, 16'h0000);
      @(negedge clk); pins[0] = 1'b1;

      // Sweep: every pin, every code, both directions (R6 R9)
      for (int i = 0; i < N; i++) begin
         for (int code = 0; code < 4; code++) begin
            for (int dir = 0; dir < 2; dir++) begin
               logic lvl0;
               logic hit;
               logic [3:0] exp_irq;
               lvl0 = (dir == 1) ? 1'b0 : 1'b1;
               hit  = expect_hit(code, dir == 1);
               wr(2'd0, 16'h0000);
               @(negedge clk); pins = {4{lvl0}};
               idle(4);
               wr(2'd1, 16'(code) << (14 - 2*i));
               wr(2'd0, 16'(1) << i);
               wr(2'd2, 16'h000F);
               idle(2);
               @(negedge clk); pins[i] = ~lvl0;
               idle(4);
               exp_irq = {4{~lvl0}};
               exp_irq[i] = hit;
               if (code == 3)
                  chk("R9 code 11 silent", {12'h0, irq}, {12'h0, exp_irq});
               else
                  chk("R6 sweep irq", {12'h0, irq}, {12'h0, exp_irq});
               rd(2'd2, v);
               chk("R7 sweep flag", v, 16'(hit) << i);
            end
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule